// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses the direction of conditional branches for an instruction front end. A table of two-bit saturating counters is indexed by the low word-address bits of the branch. A lookup reads one counter with no clock delay and reports taken when the counter is in one of its two upper states. When a branch resolves, its counter is trained one step toward the actual outcome.

A mode input selects the source of the prediction. In dynamic mode the prediction comes from the table. In static mode it comes from a hint bit that the fetch logic extracts from the branch instruction. In static mode the table keeps training, so switching back to dynamic mode finds counters that are already warm.

A small speculation tracker covers one unresolved branch. The front end may keep dispatching down the predicted path of that branch. The results of that work stay uncommitted while the tracker reports a branch in flight. If a second unresolved branch tries to dispatch before the first one resolves, the tracker raises a stall in the same cycle. Fetch may continue during the stall, but dispatch must wait.

Top module: `branch_dir_predictor`

## Requirements
- R1: The table holds 512 two-bit counters. The counter index is address bits [10:2]. Two addresses that share those bits use the same counter, and addresses that differ in any of them use separate counters.
- R2: Counter encoding is 0 = strongly not-taken, 1 = weakly not-taken, 2 = weakly taken, 3 = strongly taken. With `dyn_en`=1, `lk_taken` equals bit 1 of the indexed counter, and it follows `lk_addr` combinationally.
- R3: An update with `up_taken`=1 adds one to the indexed counter at the clock edge. A counter at 3 stays at 3.
- R4: An update with `up_taken`=0 subtracts one from the indexed counter at the clock edge. A counter at 0 stays at 0.
- R5: After reset every counter holds 1, so every address predicts not-taken in dynamic mode. A single taken update to an address then makes that address predict taken.
- R6: With `dyn_en`=0, `lk_taken` equals `lk_hint`. Updates still train the table in this mode.
- R7: If a lookup and an update hit the same counter in the same cycle, the lookup returns the value held before the update. The new value becomes visible after that clock edge.
- R8: When `br_issue` is asserted with no branch pending, the branch is accepted: `spec_stall` stays 0, and `spec_active` is 1 from the next cycle on.
- R9: When `br_issue` is asserted while a branch is pending and `br_resolve` is 0, `spec_stall` is 1 in that cycle and `spec_active` stays 1.
- R10: `br_resolve` clears `spec_active` at the next edge. If `br_issue` arrives in the same cycle, no stall is raised, the new branch is accepted and `spec_active` stays 1.
- R11: With `up_valid`=0, no counter changes, whatever `up_addr` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_en | input | 1 | 1 selects the table, 0 selects the hint bit |
| lk_addr | input | 32 | Address of the branch being looked up |
| lk_hint | input | 1 | Direction hint taken from the instruction encoding |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is being reported |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| br_issue | input | 1 | An unresolved conditional branch wants to dispatch |
| br_resolve | input | 1 | The pending branch has resolved |
| spec_active | output | 1 | A branch is in flight, so path results stay uncommitted |
| spec_stall | output | 1 | Dispatch must hold because a second branch is blocked |

## Verification
The tracker assertions assume `br_resolve` is raised only while a branch is pending, and that a stalled `br_issue` is held until it is accepted. The bench raises resolve only after an accepted issue and never pulses resolve on an idle tracker. The counter saturation checks assume `up_addr` is stable across the sampling edge. The bench changes all inputs on the falling edge. Counter values are read back through the prediction output by stepping each counter to the point where its upper bit must flip, or must not.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WNT;

  function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
    ctr_e nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : ctr_e'(cur + 2'd1);
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : ctr_e'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 512,
  localparam int IDX_W = $clog2(ENTRIES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  ctr_e mem [ENTRIES];

  ctr_e wr_old;
  ctr_e wr_new;

  assign rd_ctr = mem[rd_idx];
  assign wr_old = mem[wr_idx];
  assign wr_new = ctr_next(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_RESET;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_new;
    end
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_old == CTR_ST |=> mem[$past(wr_idx)] == CTR_ST); // R3

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && wr_old == CTR_SNT |=> mem[$past(wr_idx)] == CTR_SNT); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> mem[$past(wr_idx)] == $past(wr_old)); // R11

endmodule

// File: rtl/bp_spec_tracker.sv
module bp_spec_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic br_issue,
  input  logic br_resolve,
  output logic spec_active,
  output logic spec_stall
);

  logic pending_q;
  logic issue_ok;

  assign spec_stall  = pending_q && br_issue && !br_resolve;
  assign issue_ok    = br_issue && !spec_stall;
  assign spec_active = pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          pending_q <= 1'b0;
    else if (issue_ok)   pending_q <= 1'b1;
    else if (br_resolve) pending_q <= 1'b0;
  end

  AST_STALL_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    spec_stall |-> spec_active); // R9

  AST_STALL_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    spec_stall |=> spec_active); // R9

  AST_FIRST_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    br_issue && !spec_active |-> !spec_stall ##1 spec_active); // R8

  AST_RESOLVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    br_resolve && !br_issue |=> !spec_active); // R10

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import bp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 512,
  parameter int IDX_LSB = 2,
  localparam int IDX_W = $clog2(ENTRIES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dyn_en,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hint,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic              br_issue,
  input  logic              br_resolve,
  output logic              spec_active,
  output logic              spec_stall
);

  function automatic logic [IDX_W-1:0] addr_to_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_LSB +: IDX_W];
  endfunction

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  ctr_e             lk_ctr;
  logic             dyn_guess;

  assign lk_idx    = addr_to_idx(lk_addr);
  assign up_idx    = addr_to_idx(up_addr);
  assign dyn_guess = ctr_says_taken(lk_ctr);
  assign lk_taken  = dyn_en ? dyn_guess : lk_hint;

  bp_table #(.ENTRIES(ENTRIES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_taken (up_taken)
  );

  bp_spec_tracker u_spec (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_issue    (br_issue),
    .br_resolve  (br_resolve),
    .spec_active (spec_active),
    .spec_stall  (spec_stall)
  );

  AST_STATIC_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    !dyn_en |-> lk_taken == lk_hint); // R6

  AST_SAME_ENTRY_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_en && up_valid && lk_idx == up_idx && lk_ctr == CTR_WNT && up_taken
      |-> !lk_taken); // R7

endmodule

// File: tb/branch_dir_predictor_bench.sv
module branch_dir_predictor_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dyn_en = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        lk_hint = 1'b0;
  logic        lk_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_taken = 1'b0;
  logic        br_issue = 1'b0;
  logic        br_resolve = 1'b0;
  logic        spec_active;
  logic        spec_stall;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  branch_dir_predictor u_branch_dir_predictor (
    .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en),
    .lk_addr(lk_addr), .lk_hint(lk_hint), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
    .br_issue(br_issue), .br_resolve(br_resolve),
    .spec_active(spec_active), .spec_stall(spec_stall)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic predict(input logic [31:0] a, input string req, input logic exp);
    lk_addr = a;
    #1;
    check(req, lk_taken, exp);
  endtask

  task automatic train(input logic [31:0] a, input logic t, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      up_valid = 1'b1; up_addr = a; up_taken = t;
    end
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset;
    predict(32'h0000_0000, "R5 reset entry 0", 1'b0);
    predict(32'h0000_07FC, "R5 reset last entry", 1'b0);
    check("R8 idle after reset", spec_active, 1'b0);
    check("R9 no stall after reset", spec_stall, 1'b0);
  endtask

  task automatic t_train_up;
    train(32'h100, 1'b1, 1);
    predict(32'h100, "R5 one taken flips", 1'b1);
    train(32'h100, 1'b1, 5);
    train(32'h100, 1'b0, 1);
    predict(32'h100, "R3 saturated at 3, one down stays taken", 1'b1);
    train(32'h100, 1'b0, 1);
    predict(32'h100, "R2 counter 1 predicts not-taken", 1'b0);
  endtask

  task automatic t_train_down;
    train(32'h200, 1'b0, 5);
    train(32'h200, 1'b1, 1);
    predict(32'h200, "R4 saturated at 0, one up stays not-taken", 1'b0);
    train(32'h200, 1'b1, 1);
    predict(32'h200, "R2 counter 2 predicts taken", 1'b1);
  endtask

  task automatic t_alias;
    train(32'h300, 1'b1, 2);
    predict(32'h300 + 32'h800, "R1 bit 11 aliases", 1'b1);
    predict(32'h300 + 32'h1, "R1 bits 1:0 ignored", 1'b1);
    predict(32'h304, "R1 neighbour separate", 1'b0);
    predict(32'h500, "R1 bit 9 separate", 1'b0);
  endtask

  task automatic t_static;
    dyn_en = 1'b0;
    lk_hint = 1'b1;
    predict(32'h400, "R6 hint 1 on cold entry", 1'b1);
    lk_hint = 1'b0;
    predict(32'h300, "R6 hint 0 on trained entry", 1'b0);
    train(32'h440, 1'b1, 1);
    dyn_en = 1'b1;
    predict(32'h440, "R6 table trained while static", 1'b1);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    up_valid = 1'b1; up_addr = 32'h480; up_taken = 1'b1;
    predict(32'h480, "R7 same-cycle lookup sees old", 1'b0);
    @(negedge clk);
    up_valid = 1'b0;
    predict(32'h480, "R7 new value next cycle", 1'b1);
  endtask

  task automatic t_noupdate;
    @(negedge clk);
    up_valid = 1'b0; up_addr = 32'h600; up_taken = 1'b1;
    repeat (4) @(negedge clk);
    predict(32'h600, "R11 no write without valid", 1'b0);
    up_addr = 32'h100; up_taken = 1'b0;
    repeat (4) @(negedge clk);
    predict(32'h100, "R11 untouched entry", 1'b0);
    up_addr = 32'h200;
    repeat (2) @(negedge clk);
    predict(32'h200, "R11 taken entry kept", 1'b1);
  endtask

  task automatic t_spec;
    @(negedge clk);
    br_issue = 1'b1;
    #1 check("R8 first issue no stall", spec_stall, 1'b0);
    @(negedge clk);
    check("R8 pending after issue", spec_active, 1'b1);
    #1 check("R9 second issue stalls", spec_stall, 1'b1);
    @(negedge clk);
    check("R9 still pending", spec_active, 1'b1);
    br_resolve = 1'b1;
    #1 check("R10 resolve with issue no stall", spec_stall, 1'b0);
    @(negedge clk);
    br_issue = 1'b0;
    check("R10 new branch pending", spec_active, 1'b1);
    @(negedge clk);
    br_resolve = 1'b0;
    check("R10 resolve clears", spec_active, 1'b0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_train_up();
    t_train_down();
    t_alias();
    t_static();
    t_bypass();
    t_noupdate();
    t_spec();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule